// File: doc/BRIEF.md
# Ready-Latency Adapter (latency 1 to latency 0)

The block joins a streaming source that treats ready as a request with one cycle of latency to a sink that treats ready as an acknowledge with no latency. The source may drive a word only in the cycle after it saw `in_ready` high. The sink takes a word in any cycle where `out_valid` and `out_ready` are both high.

Both directions are registered. `out_valid`, `out_data`, `out_sop` and `out_eop` come from an output register. `in_ready` comes from a flip-flop and does not depend on the sink's `out_ready` within the same cycle. This registered ready means words can still arrive after the sink stalls. A small circular skid buffer of `DEPTH` entries, with `DEPTH` at least 2, holds them. Start and end markers travel in the same storage word as their data, so they stay aligned with it.

Top module: `rl_adapter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the buffer and drives `out_valid` and `in_ready` low. In the first cycle after reset, `in_ready` is high.
- R2: Words leave in the order they arrived. No word is lost or repeated under any pattern of sink backpressure.
- R3: `out_sop` and `out_eop` always belong to the same word as `out_data`.
- R4: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and holds `out_data`, `out_sop` and `out_eop` unchanged. A word transfers in each cycle in which `out_valid` and `out_ready` are both high.
- R5: `in_ready` is driven by a register. A change on `out_ready` never changes `in_ready` within the same cycle.
- R6: The block accepts every word the source sends in a cycle after `in_ready` was high, and the buffer never overflows. With the sink stalled and the source sending at every chance, the block holds exactly `DEPTH`+1 words and then keeps `in_ready` low.
- R7: With `out_ready` held high and the source sending at every chance, one word leaves per clock once the output register has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_ready | output | 1 | Registered request to the source; a word may follow one cycle later |
| in_valid | input | 1 | Source word present |
| in_data | input | DW | Source data |
| in_sop | input | 1 | Source start-of-packet marker |
| in_eop | input | 1 | Source end-of-packet marker |
| out_valid | output | 1 | Registered word present toward the sink |
| out_data | output | DW | Registered data toward the sink |
| out_sop | output | 1 | Registered start-of-packet marker |
| out_eop | output | 1 | Registered end-of-packet marker |
| out_ready | input | 1 | Sink acknowledge; a transfer happens when it is high together with `out_valid` |

## Verification
The bench builds the block with `DW` = 16 and `DEPTH` = 3. A depth that is not a power of two forces the read and write pointers to wrap at an explicit limit rather than by overflow. The stalled phase can then fill all four storage places: three skid entries plus the output register. Random source and sink duty cycles mix pushes and pops at every fill level. Packets of one to four words move the markers across buffer slots and across pointer wraps.

// File: rtl/rl_adapter.sv
module rl_adapter #(
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic          in_ready,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  input  logic          out_ready
);
  localparam int PW = DW + 2;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 2);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);

  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx;
  logic [PW-1:0] obuf;
  logic          ov, rdy_q;

  wire [PW-1:0] word = {in_sop, in_eop, in_data};
  wire take      = !ov || out_ready;
  wire from_fifo = take && (cnt != '0);
  wire from_in   = take && (cnt == '0) && in_valid;
  wire push      = in_valid && !from_in;

  assign cnt_nx = cnt + CW'(push) - CW'(from_fifo);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ov    <= 1'b0;
      obuf  <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (push)      wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (from_fifo) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt   <= cnt_nx;
      rdy_q <= (cnt_nx <= LIMIT);
      if (take) begin
        ov   <= from_fifo || from_in;
        obuf <= from_fifo ? mem[rp] : word;
      end
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = ov;
  assign {out_sop, out_eop, out_data} = obuf;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !in_ready));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(obuf)));

  // R6
  src_protocol_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $past(in_ready));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL) |-> (!in_valid || !push));

  // R6
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL) |-> !in_ready);
endmodule

// File: tb/sim_rl_adapter.sv
module sim_rl_adapter;
  localparam int DW = 16;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_ready, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sop, out_eop, out_ready = 1'b0;
  logic [DW-1:0] out_data;

  rl_adapter #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_ready(in_ready), .in_valid(in_valid),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_ready(out_ready));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [DW+1:0] q[$];
  int seq = 0, pos = 0, plen = 1, xfers = 0;
  bit prev_rdy = 0, prev_stall = 0;
  logic [DW+1:0] prev_word;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic cycle(input int src_pct, input int snk_pct);
    bit r_before;
    logic [DW+1:0] got, exp;
    @(negedge clk);
    if (prev_stall)  // R4
      chk(out_valid && ({out_sop, out_eop, out_data} == prev_word), "R4",
          "held word", {out_valid, out_sop, out_eop, out_data}, {1'b1, prev_word});
    r_before = in_ready;
    out_ready = ($urandom_range(99) < snk_pct);
    if (prev_rdy && ($urandom_range(99) < src_pct)) begin
      in_valid = 1'b1;
      in_data  = DW'(seq);
      in_sop   = (pos == 0);
      in_eop   = (pos == plen - 1);
      q.push_back({in_sop, in_eop, in_data});
      seq++;
      if (pos == plen - 1) begin pos = 0; plen = (plen % 4) + 1; end
      else pos++;
    end else begin
      in_valid = 1'b0;
      in_data  = DW'($urandom);
      in_sop   = $urandom_range(1);
      in_eop   = $urandom_range(1);
    end
    #1;
    chk(in_ready == r_before, "R5", "in_ready after out_ready change", in_ready, r_before);
    prev_rdy = in_ready;
    if (out_valid && out_ready) begin
      xfers++;
      got = {out_sop, out_eop, out_data};
      if (q.size() == 0) chk(0, "R2", "word with empty model", got, 0);
      else begin
        exp = q.pop_front();
        chk(got[DW-1:0] == exp[DW-1:0], "R2", "data order", got[DW-1:0], exp[DW-1:0]);
        chk(got[DW+1:DW] == exp[DW+1:DW], "R3", "sop/eop", got[DW+1:DW], exp[DW+1:DW]);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_word  = {out_sop, out_eop, out_data};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state during reset
    chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    chk(!in_ready, "R1", "in_ready in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    prev_rdy = in_ready;

    for (int i = 0; i < 3000; i++)
      cycle((i / 500) % 2 ? 90 : 50, (i / 300) % 2 ? 30 : 80);

    // R6 stalled sink fills DEPTH+1 places
    for (int i = 0; i < 40; i++) cycle(100, 0);
    chk(q.size() == DEPTH + 1, "R6", "words held while stalled", q.size(), DEPTH + 1);
    chk(!in_ready, "R6", "in_ready while full", in_ready, 0);

    // R7 full rate
    for (int i = 0; i < 10; i++) cycle(100, 100);
    xfers = 0;
    for (int i = 0; i < 100; i++) cycle(100, 100);
    chk(xfers == 100, "R7", "transfers in 100 cycles", xfers, 100);

    // R2 drain: nothing left behind
    for (int i = 0; i < 30; i++) cycle(0, 100);
    chk(q.size() == 0, "R2", "words left after drain", q.size(), 0);
    chk(!out_valid, "R2", "out_valid after drain", out_valid, 0);

    // R1 reset mid-stream
    for (int i = 0; i < 20; i++) cycle(100, 0);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R1", "outputs after mid reset",
        {out_valid, in_ready}, 0);
    rst = 1'b0;
    q.delete(); prev_stall = 0; pos = 0; plen = 1;
    @(negedge clk);
    chk(in_ready, "R1", "in_ready after mid reset", in_ready, 1);
    prev_rdy = in_ready;
    for (int i = 0; i < 400; i++) cycle(70, 60);
    for (int i = 0; i < 30; i++) cycle(0, 100);
    chk(q.size() == 0, "R2", "words left after second drain", q.size(), 0);

    finish_run();
  end
endmodule